// File: doc/BRIEF.md
# Per-Block Execution Time Statistics Aggregator

This block consumes a stream of trace point events, one per basic block entry, and keeps running timing statistics for each basic block in on-chip storage. Each event carries a block identifier, an unsigned timestamp and a context bit. The block measures how much time has passed since the previous accepted event and folds that duration into the record addressed by the identifier.

Every record is split into two halves. One half covers first-iteration executions and blocks that sit outside any loop. The other half covers later loop iterations. Each half holds the smallest duration, the largest duration, a saturating sum and a saturating execution count. Loop context tracking happens upstream, and this block takes the context bit as given.

After reset, and after each `init_i` pulse, a sweep writes neutral values into every record. While the sweep runs, the block holds off the event stream. Once a run has ended, a host downloads the records one field at a time through a small request port.

Top module: `bb_time_stats`

## Requirements
- R1: After reset, `busy_o` is high for exactly 2^ID_W cycles and `evt_ready_o` is low for that whole time. An event offered during the sweep is not accepted and changes no record.
- R2: When the sweep ends, every record holds neutral values in both halves: minimum all-ones, maximum 0, total 0, count 0.
- R3: The duration of an accepted event equals its timestamp minus the timestamp of the previous accepted event, modulo 2^TS_W. The first event after reset, or after a re-initialisation, has duration 0.
- R4: An accepted event updates only the half selected by `evt_idx_i` (0 = first iteration, 1 = later iterations). The minimum becomes the smaller of the stored value and the duration, and the maximum becomes the larger. The total grows by the duration and the count grows by one. The other half is left unchanged.
- R5: Events may arrive back to back on consecutive cycles, including events that address the same record, and no update is lost.
- R6: The total saturates at all-ones instead of wrapping.
- R7: The count saturates at all-ones instead of wrapping.
- R8: A host read is requested with `rd_req_i`, `rd_addr_i` and `rd_field_i`. Bit 2 of `rd_field_i` selects the half (0 first, 1 later). Bits 1:0 select the field: 0 minimum, 1 maximum, 2 total, 3 count. The value appears zero-extended on `rd_data_o`, with `rd_valid_o` high, exactly one cycle after the request. `rd_valid_o` is low in any cycle that follows a cycle without a request.
- R9: A pulse on `init_i` while `busy_o` is low restarts the sweep on the next cycle. After that sweep, all records are neutral again and the next event has duration 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Restart the initialisation sweep |
| busy_o | output | 1 | Initialisation sweep in progress |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | Event can be accepted |
| evt_id_i | input | ID_W | Basic block identifier (record address) |
| evt_ts_i | input | TS_W | Event timestamp |
| evt_idx_i | input | 1 | Context: 0 first iteration, 1 later iteration |
| rd_req_i | input | 1 | Host read request |
| rd_addr_i | input | ID_W | Record to read |
| rd_field_i | input | 3 | Half and field select |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | RD_W | Read data, zero-extended |

## Verification
The checker assumes two things about the host. It issues read requests only while no event is being offered, and it pulses `init_i` only when the sweep is idle and the update pipeline has drained. Under these conditions, every host read sees completed records, and every sweep starts from a quiet state.

The stimulus respects these limits. It leaves at least three idle cycles after the last event before any read or re-initialisation. It offers events during a sweep only to show that they are refused.

Timestamps in the stimulus wrap past the top of their range, so the modular duration rule is exercised.

// File: rtl/bbts_pkg.sv
package bbts_pkg;
  localparam int FSEL_W = 3;
  localparam logic [1:0] FLD_MIN = 2'd0;
  localparam logic [1:0] FLD_MAX = 2'd1;
  localparam logic [1:0] FLD_TOT = 2'd2;
  localparam logic [1:0] FLD_CNT = 2'd3;
  localparam logic CTX_FIRST = 1'b0;
  localparam logic CTX_LATER = 1'b1;
endpackage

// File: rtl/bbts_delta.sv
module bbts_delta #(
  parameter int TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            acc_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] dur_o
);
  logic            have_q;
  logic [TS_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      prev_q <= '0;
    end else if (clr_i) begin
      have_q <= 1'b0;
    end else if (acc_i) begin
      have_q <= 1'b1;
      prev_q <= ts_i;
    end
  end

  // modular difference; first event after reset/init measures zero
  assign dur_o = have_q ? (ts_i - prev_q) : '0;
endmodule

// File: rtl/bbts_sweep.sv
module bbts_sweep #(
  parameter int ID_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            busy_o,
  output logic [ID_W-1:0] ptr_o
);
  localparam logic [ID_W-1:0] LAST = '1;

  logic            busy_q;
  logic [ID_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/bbts_upd.sv
module bbts_upd #(
  parameter int TS_W  = 64,
  parameter int TOT_W = 64,
  parameter int CNT_W = 32,
  localparam int HALF_W = 2*TS_W + TOT_W + CNT_W
) (
  input  logic [HALF_W-1:0] half_i,
  input  logic [TS_W-1:0]   dur_i,
  output logic [HALF_W-1:0] half_o
);
  logic [TS_W-1:0]  min_c, max_c, min_n, max_n;
  logic [TOT_W-1:0] tot_c, tot_n;
  logic [CNT_W-1:0] cnt_c, cnt_n;
  logic [TOT_W:0]   sum;

  assign min_c = half_i[HALF_W-1 -: TS_W];
  assign max_c = half_i[HALF_W-TS_W-1 -: TS_W];
  assign tot_c = half_i[CNT_W +: TOT_W];
  assign cnt_c = half_i[0 +: CNT_W];

  assign sum   = {1'b0, tot_c} + (TOT_W+1)'(dur_i);
  assign min_n = (dur_i < min_c) ? dur_i : min_c;
  assign max_n = (dur_i > max_c) ? dur_i : max_c;
  assign tot_n = sum[TOT_W] ? '1 : sum[TOT_W-1:0];
  assign cnt_n = (&cnt_c) ? cnt_c : cnt_c + 1'b1;

  assign half_o = {min_n, max_n, tot_n, cnt_n};
endmodule

// File: rtl/bbts_store.sv
module bbts_store #(
  parameter int ID_W  = 6,
  parameter int REC_W = 448,
  localparam int DEPTH = 1 << ID_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [ID_W-1:0]  waddr_i,
  input  logic [REC_W-1:0] wdata_i,
  input  logic [ID_W-1:0]  raddr_a_i,
  output logic [REC_W-1:0] rdata_a_o,
  input  logic [ID_W-1:0]  raddr_b_i,
  output logic [REC_W-1:0] rdata_b_o
);
  logic [REC_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/bb_time_stats.sv
module bb_time_stats
  import bbts_pkg::*;
#(
  parameter int TS_W  = 64,
  parameter int TOT_W = 64,
  parameter int CNT_W = 32,
  parameter int ID_W  = 6,
  parameter int RD_W  = (TOT_W > TS_W) ? TOT_W : TS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  output logic              busy_o,
  input  logic              evt_valid_i,
  output logic              evt_ready_o,
  input  logic [ID_W-1:0]   evt_id_i,
  input  logic [TS_W-1:0]   evt_ts_i,
  input  logic              evt_idx_i,
  input  logic              rd_req_i,
  input  logic [ID_W-1:0]   rd_addr_i,
  input  logic [FSEL_W-1:0] rd_field_i,
  output logic              rd_valid_o,
  output logic [RD_W-1:0]   rd_data_o
);
  localparam int HALF_W = 2*TS_W + TOT_W + CNT_W;
  localparam int REC_W  = 2*HALF_W;
  localparam logic [HALF_W-1:0] NEUTRAL_HALF = {{TS_W{1'b1}}, {(HALF_W-TS_W){1'b0}}};

  logic            busy, acc, restart;
  logic [ID_W-1:0] sweep_ptr;
  logic [TS_W-1:0] dur;

  assign evt_ready_o = ~busy;
  assign busy_o      = busy;
  assign acc         = evt_valid_i & ~busy;
  assign restart     = init_i & ~busy;

  bbts_sweep #(.ID_W(ID_W)) u_sweep (
    .clk_i, .rst_ni, .start_i(restart), .busy_o(busy), .ptr_o(sweep_ptr)
  );

  bbts_delta #(.TS_W(TS_W)) u_delta (
    .clk_i, .rst_ni, .clr_i(restart), .acc_i(acc), .ts_i(evt_ts_i), .dur_o(dur)
  );

  // stage 1: registered read of the addressed record
  logic             s1_vld_q, s1_idx_q;
  logic [ID_W-1:0]  s1_id_q;
  logic [TS_W-1:0]  s1_dur_q;
  logic [REC_W-1:0] s1_rec_q;
  // last written record, for forwarding
  logic             wr_vld_q;
  logic [ID_W-1:0]  wr_id_q;
  logic [REC_W-1:0] wr_rec_q;

  logic [REC_W-1:0] rdata_a, rdata_b, base, nxt, wdata;
  logic [ID_W-1:0]  waddr;
  logic             we;

  assign base = (wr_vld_q && wr_id_q == s1_id_q) ? wr_rec_q : s1_rec_q;

  for (genvar c = 0; c < 2; c++) begin : g_ctx
    logic [HALF_W-1:0] upd_half;
    bbts_upd #(.TS_W(TS_W), .TOT_W(TOT_W), .CNT_W(CNT_W)) u_upd (
      .half_i(base[c*HALF_W +: HALF_W]), .dur_i(s1_dur_q), .half_o(upd_half)
    );
    assign nxt[c*HALF_W +: HALF_W] =
      (s1_idx_q == 1'(c)) ? upd_half : base[c*HALF_W +: HALF_W];
  end

  assign we    = busy | s1_vld_q;
  assign waddr = busy ? sweep_ptr : s1_id_q;
  assign wdata = busy ? {NEUTRAL_HALF, NEUTRAL_HALF} : nxt;

  bbts_store #(.ID_W(ID_W), .REC_W(REC_W)) u_store (
    .clk_i,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(evt_id_i), .rdata_a_o(rdata_a),
    .raddr_b_i(rd_addr_i), .rdata_b_o(rdata_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_idx_q <= 1'b0;
      s1_id_q  <= '0;
      s1_dur_q <= '0;
      s1_rec_q <= '0;
      wr_vld_q <= 1'b0;
      wr_id_q  <= '0;
      wr_rec_q <= '0;
    end else begin
      s1_vld_q <= acc;
      s1_idx_q <= evt_idx_i;
      s1_id_q  <= evt_id_i;
      s1_dur_q <= dur;
      s1_rec_q <= rdata_a;
      wr_vld_q <= s1_vld_q & ~busy & ~restart;
      wr_id_q  <= s1_id_q;
      wr_rec_q <= nxt;
    end
  end

  // host read path
  logic [HALF_W-1:0] rd_half;
  logic [RD_W-1:0]   rd_sel;
  logic              rd_valid_q;
  logic [RD_W-1:0]   rd_data_q;

  always_comb begin
    rd_half = (rd_field_i[2] == CTX_LATER) ? rdata_b[REC_W-1 -: HALF_W]
                                           : rdata_b[HALF_W-1:0];
    rd_sel = '0;
    case (rd_field_i[1:0])
      FLD_MIN: rd_sel[TS_W-1:0]  = rd_half[HALF_W-1 -: TS_W];
      FLD_MAX: rd_sel[TS_W-1:0]  = rd_half[HALF_W-TS_W-1 -: TS_W];
      FLD_TOT: rd_sel[TOT_W-1:0] = rd_half[CNT_W +: TOT_W];
      default: rd_sel[CNT_W-1:0] = rd_half[0 +: CNT_W];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req_i;
      if (rd_req_i) rd_data_q <= rd_sel;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/bbts_chk.sv
module bbts_chk #(
  parameter int ID_W = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic init_i,
  input logic busy_o,
  input logic evt_valid_i,
  input logic evt_ready_o,
  input logic rd_req_i,
  input logic rd_valid_o
);
  localparam int DEPTH = 1 << ID_W;

  logic [ID_W+1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else             busy_cnt_q <= '0;
  end

  // R1
  init_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt_q == (ID_W+2)'(DEPTH)));

  // R9
  init_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !busy_o) |=> (busy_o && !evt_ready_o));

  // R8
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);

  // R8
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);

  // R8
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |-> !evt_valid_i);
endmodule

bind bb_time_stats bbts_chk #(.ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .busy_o(busy_o),
  .evt_valid_i(evt_valid_i), .evt_ready_o(evt_ready_o),
  .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o)
);

// File: tb/tb_bb_time_stats.sv
`timescale 1ns/1ps
module tb_bb_time_stats;
  localparam int TS_W = 16, TOT_W = 16, CNT_W = 4, ID_W = 3, RD_W = 16;
  localparam int NREC = 1 << ID_W;

  logic clk_i = 1'b0, rst_ni = 1'b0, init_i = 1'b0;
  logic busy_o, evt_valid_i = 1'b0, evt_ready_o, evt_idx_i = 1'b0;
  logic [ID_W-1:0] evt_id_i = '0, rd_addr_i = '0;
  logic [TS_W-1:0] evt_ts_i = '0;
  logic rd_req_i = 1'b0, rd_valid_o;
  logic [2:0] rd_field_i = '0;
  logic [RD_W-1:0] rd_data_o;

  always #4 clk_i = ~clk_i;

  bb_time_stats #(.TS_W(TS_W), .TOT_W(TOT_W), .CNT_W(CNT_W), .ID_W(ID_W), .RD_W(RD_W)) dut (
    .clk_i, .rst_ni, .init_i, .busy_o, .evt_valid_i, .evt_ready_o, .evt_id_i,
    .evt_ts_i, .evt_idx_i, .rd_req_i, .rd_addr_i, .rd_field_i, .rd_valid_o, .rd_data_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_min [NREC][2];
  logic [15:0] m_max [NREC][2];
  logic [15:0] m_tot [NREC][2];
  logic [15:0] m_cnt [NREC][2];
  logic [15:0] prev_ts = '0;
  bit have_prev = 0;
  logic [15:0] ts = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int a = 0; a < NREC; a++)
      for (int c = 0; c < 2; c++) begin
        m_min[a][c] = 16'hFFFF; m_max[a][c] = '0; m_tot[a][c] = '0; m_cnt[a][c] = '0;
      end
    have_prev = 0;
  endtask

  task automatic send(input int id, input bit idx, input logic [15:0] t);
    logic [15:0] d;
    logic [16:0] s;
    evt_valid_i = 1'b1; evt_id_i = ID_W'(id); evt_idx_i = idx; evt_ts_i = t;
    @(posedge clk_i);
    d = have_prev ? t - prev_ts : 16'd0;
    prev_ts = t; have_prev = 1;
    if (d < m_min[id][idx]) m_min[id][idx] = d;
    if (d > m_max[id][idx]) m_max[id][idx] = d;
    s = {1'b0, m_tot[id][idx]} + {1'b0, d};
    m_tot[id][idx] = s[16] ? 16'hFFFF : s[15:0];
    if (m_cnt[id][idx] != 16'd15) m_cnt[id][idx] = m_cnt[id][idx] + 16'd1;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  function automatic logic [15:0] expect_of(input int a, input int f);
    int c = f >> 2;
    case (f & 3)
      0: return m_min[a][c];
      1: return m_max[a][c];
      2: return m_tot[a][c];
      default: return m_cnt[a][c];
    endcase
  endfunction

  task automatic read_one(input int a, input int f, output logic [15:0] v, output bit vld);
    rd_req_i = 1'b1; rd_addr_i = ID_W'(a); rd_field_i = 3'(f);
    @(posedge clk_i); @(negedge clk_i);
    rd_req_i = 1'b0;
    v = rd_data_o; vld = rd_valid_o;
  endtask

  task automatic read_all(input string req);
    logic [15:0] v;
    bit vld;
    repeat (3) @(negedge clk_i);
    for (int a = 0; a < NREC; a++)
      for (int f = 0; f < 8; f++) begin
        read_one(a, f, v, vld);
        chk(vld && v == expect_of(a, f), req, {15'd0, vld, v}, {16'd1, expect_of(a, f)});
      end
    @(negedge clk_i);
    chk(!rd_valid_o, "R8 valid drops", 32'(rd_valid_o), 32'd0);
  endtask

  task automatic wait_sweep(output int len);
    len = 0;
    while (busy_o) begin
      len++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    logic [15:0] v;
    bit vld;
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(busy_o && !evt_ready_o, "R1 busy after reset", {busy_o, evt_ready_o}, 32'b10);
    // R1: event offered during sweep must be refused
    evt_valid_i = 1'b1; evt_id_i = 3'd5; evt_idx_i = 1'b0; evt_ts_i = 16'd100;
    wait_sweep(len);
    evt_valid_i = 1'b0;
    chk(len == NREC, "R1 sweep length", 32'(len), 32'(NREC));
    chk(evt_ready_o, "R1 ready after sweep", 32'(evt_ready_o), 32'd1);
    read_all("R2 neutral after reset / R1 record untouched");

    // R3 first event zero, R4 mixed ids/contexts
    ts = 16'd1000;
    send(2, 0, ts);
    for (int i = 0; i < 24; i++) begin
      ts = ts + 16'(5 + (i * 7) % 13);
      send((i * 3) % NREC, 1'((i >> 1) & 1), ts);
    end
    // R5 back-to-back same record, alternating contexts
    for (int i = 0; i < 6; i++) begin
      ts = ts + 16'(3 + i * 4);
      send(4, 1'(i & 1), ts);
    end
    for (int i = 0; i < 5; i++) begin
      ts = ts + 16'(9 - i);
      send(6, 1'b1, ts);
    end
    // R3 timestamp wraps
    ts = 16'hFFF0;
    send(7, 0, ts);
    ts = ts + 16'h0020;
    send(7, 0, ts);
    read_all("R4 R5 R3 stream update");

    // R9 re-init
    @(negedge clk_i);
    init_i = 1'b1;
    @(negedge clk_i);
    init_i = 1'b0;
    chk(busy_o, "R9 restart busy", 32'(busy_o), 32'd1);
    wait_sweep(len);
    chk(len == NREC, "R9 sweep length", 32'(len), 32'(NREC));
    model_clear();
    read_all("R9 neutral after re-init");

    // R6 R7 saturation; first event after re-init has duration 0 (R9)
    ts = 16'd50;
    for (int i = 0; i < 20; i++) begin
      send(1, 1'b1, ts);
      ts = ts + 16'd30000;
    end
    repeat (3) @(negedge clk_i);
    read_one(1, 4, v, vld);
    chk(vld && v == 16'd0, "R9 first duration zero", 32'(v), 32'd0);
    read_one(1, 6, v, vld);
    chk(vld && v == 16'hFFFF, "R6 total saturates", 32'(v), 32'hFFFF);
    read_one(1, 7, v, vld);
    chk(vld && v == 16'd15, "R7 count saturates", 32'(v), 32'd15);
    read_all("R6 R7 saturation record");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule